// File: doc/BRIEF.md
# Multi-function 32-bit ALU

A purely combinational arithmetic-logic unit. It takes two operands and a four-bit operation select and returns one result word and a zero flag in the same cycle. The operations are bitwise AND, OR and XOR, two's-complement add and subtract, signed set-on-less-than, logical shifts in both directions and a multiply that keeps only the low half of the product.

The unit holds no state. It drives no carry, overflow or exception outputs. It is meant to sit in the execute stage of a simple integer pipeline. The surrounding stage registers its inputs and outputs, and the unit contributes only combinational depth between those registers. The operand width is a parameter; the default is 32 bits.

Top module: `alu_unit`

## Requirements
- R1: Select 4'b0000 drives the result with the bitwise AND of A and B.
- R2: Select 4'b0001 drives the result with the bitwise OR of A and B.
- R3: Select 4'b0111 drives the result with the bitwise XOR of A and B.
- R4: Select 4'b0010 drives the result with A+B, wrapped to 32 bits.
- R5: Select 4'b0100 drives the result with A-B, wrapped to 32 bits.
- R6: Select 4'b1000 drives the result with 1 when A is less than B as signed two's-complement values, and with 0 otherwise.
- R7: Select 4'b0011 shifts A left logically by B[4:0] and fills with zeros.
- R8: Select 4'b0101 shifts A right logically by B[4:0] and fills with zeros.
- R9: Select 4'b0110 drives the result with the low 32 bits of the unsigned product A*B.
- R10: For both shift selects, bits B[31:5] have no effect on the result.
- R11: Every select from 4'b1001 to 4'b1111 drives the result with 0.
- R12: The zero flag is 1 exactly when the 32-bit result is all zeros, for every select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand, and the value that is shifted |
| b_i | input | 32 | Second operand; bits [4:0] give the shift amount |
| op_i | input | 4 | Operation select |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The unit has no state, so any fault shows on result_o or zero_o in the same cycle that the failing select and operands are applied. The faults most likely to escape are at the edges of the operations. A wrong overflow term in the signed compare shows only when the operands have opposite signs at the extremes. A shifter stage that is miswired shows only for certain amounts, or when B has upper bits set. A decode slip shows only for the unlisted select values. For this reason, directed vectors aimed at each of these cases run next to a large set of random vectors that covers all sixteen selects.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SLL = 4'b0011,
    OP_SUB = 4'b0100,
    OP_SRL = 4'b0101,
    OP_MUL = 4'b0110,
    OP_XOR = 4'b0111,
    OP_SLT = 4'b1000
  } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
// Shared adder: add, subtract and the signed compare all use one carry chain.
module alu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              lt_o
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              ovf;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = a_i + b_eff + DATA_W'(sub_i);
    // signed overflow of a - b
    ovf   = (a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ sum_o[MSB]);
    lt_o  = sum_o[MSB] ^ ovf;
  end

endmodule

// File: rtl/alu_shift.sv
// One right barrel shifter; left shifts reverse the data on the way in and out.
module alu_shift #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               left_i,
  output logic [DATA_W-1:0]  data_o
);

  logic [DATA_W-1:0] stage [SHAMT_W+1];
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      rev_in[i] = data_i[DATA_W-1-i];
    end
  end

  assign stage[0] = left_i ? rev_in : data_i;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int unsigned DIST = 1 << s;
    assign stage[s+1] = amt_i[s] ? (stage[s] >> DIST) : stage[s];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      rev_out[i] = stage[SHAMT_W][DATA_W-1-i];
    end
  end

  assign data_o = left_i ? rev_out : stage[SHAMT_W];

endmodule

// File: rtl/alu_mul.sv
// Low-half multiplier: only partial-product bits under DATA_W are formed.
module alu_mul #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] prod_o
);

  logic [DATA_W-1:0] acc [DATA_W+1];

  assign acc[0] = '0;

  for (genvar r = 0; r < DATA_W; r++) begin : g_row
    assign acc[r+1] = acc[r] + (b_i[r] ? (a_i << r) : '0);
  end

  assign prod_o = acc[DATA_W];

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);

  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sum;
  logic              lt;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] prod;
  logic              do_sub;
  logic              do_left;

  assign do_sub  = (op_i == OP_SUB) || (op_i == OP_SLT);
  assign do_left = (op_i == OP_SLL);

  alu_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (do_sub),
    .sum_o (sum),
    .lt_o  (lt)
  );

  alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) i_shift (
    .data_i (a_i),
    .amt_i  (b_i[SHAMT_W-1:0]),
    .left_i (do_left),
    .data_o (shifted)
  );

  alu_mul #(.DATA_W(DATA_W)) i_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod)
  );

  always_comb begin
    case (op_i)
      OP_AND:         result_o = a_i & b_i;
      OP_OR:          result_o = a_i | b_i;
      OP_XOR:         result_o = a_i ^ b_i;
      OP_ADD, OP_SUB: result_o = sum;
      OP_SLT:         result_o = DATA_W'(lt);
      OP_SLL, OP_SRL: result_o = shifted;
      OP_MUL:         result_o = prod;
      default:        result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;

endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              zero_o
);

  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] low_mask;
  assign low_mask = (DATA_W'(1) << b_i[SHAMT_W-1:0]) - DATA_W'(1);

  always_comb begin
    if (op_i == OP_AND) begin
      a_r1_and_within_a: assert ((result_o & ~a_i) == '0)
        else $error("AND result has bits outside A");
    end
    if (op_i == OP_OR) begin
      a_r2_or_covers_a: assert ((result_o & a_i) == a_i)
        else $error("OR result lost bits of A");
    end
    if (op_i == OP_ADD) begin
      a_r4_add_lsb: assert (result_o[0] == (a_i[0] ^ b_i[0]))
        else $error("ADD low bit wrong");
    end
    if (op_i == OP_SUB) begin
      a_r12_sub_zero_iff_equal: assert (zero_o == (a_i == b_i))
        else $error("SUB zero flag disagrees with operand equality");
    end
    if (op_i == OP_SLT) begin
      a_r6_slt_boolean: assert (result_o[DATA_W-1:1] == '0)
        else $error("SLT result not 0 or 1");
    end
    if (op_i == OP_SLL) begin
      a_r7_sll_low_clear: assert ((result_o & low_mask) == '0)
        else $error("SLL left nonzero bits below the shift amount");
    end
    if (op_i >= OP_W'(9)) begin
      a_r11_unlisted_zero: assert (result_o == '0 && zero_o)
        else $error("unlisted select gave nonzero result or clear flag");
    end
  end

endmodule

bind alu_unit alu_unit_chk #(.DATA_W(DATA_W)) i_alu_unit_chk (.*);

// File: tb/test_alu_unit.sv
`timescale 1ns/1ps
module test_alu_unit;

  localparam int unsigned W = 32;

  logic         clk;
  logic         rst_ni;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [3:0]   op;
  logic [W-1:0] res;
  logic         zero;

  int n_cmp  = 0;
  int n_fail = 0;

  alu_unit #(.DATA_W(W)) i_alu_unit (
    .a_i      (a),
    .b_i      (b),
    .op_i     (op),
    .result_o (res),
    .zero_o   (zero)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] ref_result(input logic [3:0] o,
                                               input logic [W-1:0] x,
                                               input logic [W-1:0] y);
    logic [2*W-1:0] full;
    case (o)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0111: return x ^ y;
      4'b0010: return x + y;
      4'b0100: return x - y;
      4'b1000: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'b0011: return x << y[4:0];
      4'b0101: return x >> y[4:0];
      4'b0110: begin
        full = {32'd0, x} * {32'd0, y};
        return full[W-1:0];
      end
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0111: return "R3";
      4'b0010: return "R4";
      4'b0100: return "R5";
      4'b1000: return "R6";
      4'b0011: return "R7";
      4'b0101: return "R8";
      4'b0110: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x,
                       input logic [W-1:0] y, input string tag);
    logic [W-1:0] exp_r;
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    exp_r = ref_result(o, x, y);
    n_cmp++;
    if (res !== exp_r) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h result=%h expected=%h", tag, o, x, y, res, exp_r);
    end
    n_cmp++;
    if (zero !== (exp_r == '0)) begin
      n_fail++;
      $display("FAIL R12 op=%b a=%h b=%h zero=%b expected=%b", o, x, y, zero, exp_r == '0);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] r_a, r_b;
    logic [W-1:0] sh_r;
    rst_ni = 1'b0;
    op = '0; a = '0; b = '0;
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // idle state: all-zero inputs, AND select
    apply(4'b0000, '0, '0, "R1");

    // R1 R2 R3 bitwise patterns
    apply(4'b0000, 32'hF0F0_A5A5, 32'hFF00_0FF0, "R1");
    apply(4'b0001, 32'h0000_0000, 32'h0000_0000, "R2");
    apply(4'b0001, 32'h1234_0000, 32'h0000_5678, "R2");
    apply(4'b0111, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R3");
    apply(4'b0111, 32'hAAAA_AAAA, 32'h5555_5555, "R3");
    // R4 R5 wrap and equality
    apply(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, "R4");
    apply(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001, "R4");
    apply(4'b0100, 32'h0000_0000, 32'h0000_0001, "R5");
    apply(4'b0100, 32'h1357_9BDF, 32'h1357_9BDF, "R5");
    // R6 signed compare at extremes
    apply(4'b1000, 32'h8000_0000, 32'h7FFF_FFFF, "R6");
    apply(4'b1000, 32'h7FFF_FFFF, 32'h8000_0000, "R6");
    apply(4'b1000, 32'hFFFF_FFFF, 32'h0000_0000, "R6");
    apply(4'b1000, 32'h0000_0005, 32'h0000_0005, "R6");
    // R7 R8 amounts 0 and 31
    apply(4'b0011, 32'h8000_0001, 32'd0, "R7");
    apply(4'b0011, 32'h0000_0003, 32'd31, "R7");
    apply(4'b0101, 32'h8000_0000, 32'd31, "R8");
    apply(4'b0101, 32'hFFFF_FFFF, 32'd16, "R8");
    // R10 upper bits of B ignored by shifts
    apply(4'b0011, 32'h0000_00FF, 32'hFFFF_FFE4, "R10");
    apply(4'b0101, 32'hFF00_0000, 32'h8000_0028, "R10");
    apply(4'b0101, 32'h0000_0001, 32'hFFFF_FFE0, "R10");
    // R9 truncation
    apply(4'b0110, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9");
    apply(4'b0110, 32'h0001_0000, 32'h0001_0000, "R9");
    apply(4'b0110, 32'h0000_1234, 32'h0000_0010, "R9");
    // R11 every unlisted select
    for (int u = 9; u < 16; u++) begin
      apply(4'(u), 32'hFFFF_FFFF, 32'h1234_5678, "R11");
    end

    // random sweep over all selects
    for (int i = 0; i < 1500; i++) begin
      for (int o = 0; o < 16; o++) begin
        r_a = $urandom();
        r_b = $urandom();
        if (i % 7 == 0) r_b = r_a;
        if (i % 11 == 0) r_a = '0;
        apply(4'(o), r_a, r_b, req_of(4'(o)));
      end
    end

    // R10 paired: same low 5 bits, different upper bits, identical result
    for (int i = 0; i < 200; i++) begin
      r_a = $urandom();
      r_b = $urandom();
      apply(4'b0011, r_a, r_b, "R10");
      sh_r = res;
      apply(4'b0011, r_a, {~r_b[31:5], r_b[4:0]}, "R10");
      n_cmp++;
      if (res !== sh_r) begin
        n_fail++;
        $display("FAIL R10 upper B bits changed shift: result=%h expected=%h", res, sh_r);
      end
    end

    finish_run();
  end

endmodule